// File: doc/BRIEF.md
# DRAM Refresh Timer and Controller

This block keeps external DRAM alive for a bus controller. An 8-bit interval counter advances on ticks from a selectable prescaler of the system clock. When the counter equals a programmed compare value, the counter returns to zero and a refresh request is raised. Once no DRAM access is in progress, the block drives a CAS-before-RAS (CBR) refresh on the active-low RAS and CAS strobes. A mode bit decides whether other external, non-DRAM bus traffic may continue during the strobe phase. When the chip enters standby, the block leaves the strobes in self-refresh until standby is released.

Software sets up the block through a small write port with four addresses. Refresh is active only when the enable bit is set and the space-type field marks at least one area as DRAM. The counter and the compare value should be loaded before a nonzero clock select is written, because the counter starts as soon as the select is nonzero. The bus arbiter reports an ongoing DRAM access on `dram_busy`. The block answers on `dram_block`, which keeps new DRAM accesses off the bus while a refresh or precharge runs, and on `ext_hold`, which holds off non-DRAM accesses.

The controller is a state machine with these states: IDLE, PEND (request waiting), CAS_LEAD, BOTH_A, BOTH_B, PRECH, SR_CAS and SR_HOLD. Its transitions are:

- IDLE to SR_CAS, on standby while refresh is active and the bus is free.
- IDLE to PEND, on a compare match while refresh is active.
- PEND to IDLE, if refresh is turned off.
- PEND to CAS_LEAD, once `dram_busy` is low.
- CAS_LEAD to BOTH_A to BOTH_B to PRECH to IDLE, unconditionally, one clock each.
- SR_CAS to SR_HOLD, unconditionally.
- SR_HOLD to IDLE, when standby falls.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, `ras_n` and `cas_n` are 1, `refresh_req`, `ext_hold`, `dram_block` and `overrun` are 0, and `count_out` is 0.
- R2: Address 0 is the control register: bit 0 enables refresh, bit 1 selects hold mode, and bits 4:2 are the clock select. Address 1 holds the compare value, address 2 loads the counter, and address 3 bits 2:0 are the space-type field. With clock select 000 the counter holds its value.
- R3: Clock select values 1 to 7 advance the counter once every 2, 8, 32, 128, 512, 2048 or 4096 clocks respectively.
- R4: On a counter tick with the counter equal to the compare value, the counter becomes 0, and `refresh_req` is 1 in the following cycle. Matches therefore recur every ratio×(compare+1) clocks.
- R5: No refresh request or strobe activity occurs while the enable bit is 0 or the space-type field is 000.
- R6: A CBR cycle is as follows. In the cycle after the request is seen with `dram_busy` low, `cas_n` is 0 and `ras_n` is 1. Both strobes are then 0 for 2 clocks. Both then return to 1 together, and one precharge clock follows with `dram_block` still 1.
- R7: While `dram_busy` is 1, a pending request waits with both strobes high. CAS falls in the cycle after `dram_busy` drops.
- R8: With hold mode 1, `ext_hold` is 1 during the three strobe-active CBR clocks. With hold mode 0, `ext_hold` stays 0.
- R9: A compare match while a request is pending or being served sets `overrun`, which stays 1 until reset.
- R10: Standby entry proceeds as follows. In the next cycle `cas_n` falls alone. `ras_n` follows one cycle later, and both stay 0 while the counter is frozen. After standby falls, both strobes are 1 in the next cycle and the counter restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 control, 1 compare, 2 counter, 3 space type) |
| cfg_wdata | input | 8 | Register write data |
| dram_busy | input | 1 | A DRAM access is in progress |
| standby | input | 1 | Chip standby state |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| refresh_req | output | 1 | Refresh request is pending |
| ext_hold | output | 1 | Non-DRAM external accesses must wait |
| dram_block | output | 1 | New DRAM accesses must wait |
| overrun | output | 1 | Sticky flag for a missed refresh interval |
| count_out | output | 8 | Current interval counter value |

## Verification
The hardest state to reach from the ports is an overrun. It needs a second compare match while the first request is still unserved. The stimulus gets there by choosing the shortest interval (select 1, compare 0) and holding `dram_busy` high, so the request cannot leave the pending state. The exact match period is also hard to see, because the prescaler phase is hidden. Random select and compare pairs are therefore checked by measuring the distance between two successive request rises, which does not depend on that phase. Self-refresh wake-up timing is made exact by the prescaler restart on exit, which the bench relies on for its counter check.

// File: rtl/dref_pkg.sv
package dref_pkg;
    localparam int CNT_W = 8;
    localparam int DIV_W = 12;
    localparam int SEL_W = 3;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_CMP   = 2'd1;
    localparam logic [1:0] ADDR_CNT   = 2'd2;
    localparam logic [1:0] ADDR_SPACE = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_CAS_LEAD,
        ST_BOTH_A,
        ST_BOTH_B,
        ST_PRECH,
        ST_SR_CAS,
        ST_SR_HOLD
    } dref_state_e;
endpackage

// File: rtl/dref_prescaler.sv
module dref_prescaler #(
    parameter int DIV_W = 12,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Low-bit masks give divide ratios 2, 8, 32, 128, 512, 2048, 4096.
    always_comb begin
        unique case (sel)
            3'd1:    mask = DIV_W'(12'h001);
            3'd2:    mask = DIV_W'(12'h007);
            3'd3:    mask = DIV_W'(12'h01F);
            3'd4:    mask = DIV_W'(12'h07F);
            3'd5:    mask = DIV_W'(12'h1FF);
            3'd6:    mask = DIV_W'(12'h7FF);
            3'd7:    mask = DIV_W'(12'hFFF);
            default: mask = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        div_q <= '0;
        else if (restart || sel == '0)     div_q <= '0;
        else                               div_q <= div_q + 1'b1;
    end

    assign tick = (sel != '0) && !restart && ((div_q & mask) == mask);
endmodule

// File: rtl/dref_counter.sv
module dref_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic             clear,
    input  logic             ld_we,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    logic advance;

    assign advance = tick && !hold && !clear && !ld_we;
    assign match   = advance && (cnt == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (ld_we)   cnt <= ld_val;
        else if (clear)   cnt <= '0;
        else if (match)   cnt <= '0;
        else if (advance) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dref_fsm.sv
module dref_fsm
    import dref_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic match,
    input  logic dram_busy,
    input  logic standby,
    input  logic hold_mode,
    output logic ras_n,
    output logic cas_n,
    output logic refresh_req,
    output logic ext_hold,
    output logic dram_block,
    output logic overrun,
    output logic in_self,
    output logic sr_exit
);
    dref_state_e state_q, state_d;
    logic        busy_cycle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (active && standby && !dram_busy) state_d = ST_SR_CAS;
                else if (active && match)            state_d = ST_PEND;
            end
            ST_PEND: begin
                if (!active)        state_d = ST_IDLE;
                else if (!dram_busy) state_d = ST_CAS_LEAD;
            end
            ST_CAS_LEAD: state_d = ST_BOTH_A;
            ST_BOTH_A:   state_d = ST_BOTH_B;
            ST_BOTH_B:   state_d = ST_PRECH;
            ST_PRECH:    state_d = ST_IDLE;
            ST_SR_CAS:   state_d = ST_SR_HOLD;
            ST_SR_HOLD:  if (!standby) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ras_n       = 1'b1;
        cas_n       = 1'b1;
        refresh_req = 1'b0;
        ext_hold    = 1'b0;
        dram_block  = 1'b0;
        in_self     = 1'b0;
        busy_cycle  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PEND: begin
                refresh_req = 1'b1;
                busy_cycle  = 1'b1;
            end
            ST_CAS_LEAD: begin
                cas_n      = 1'b0;
                ext_hold   = hold_mode;
                dram_block = 1'b1;
                busy_cycle = 1'b1;
            end
            ST_BOTH_A, ST_BOTH_B: begin
                cas_n      = 1'b0;
                ras_n      = 1'b0;
                ext_hold   = hold_mode;
                dram_block = 1'b1;
                busy_cycle = 1'b1;
            end
            ST_PRECH: begin
                dram_block = 1'b1;
                busy_cycle = 1'b1;
            end
            ST_SR_CAS: begin
                cas_n      = 1'b0;
                dram_block = 1'b1;
                in_self    = 1'b1;
            end
            ST_SR_HOLD: begin
                cas_n      = 1'b0;
                ras_n      = 1'b0;
                dram_block = 1'b1;
                in_self    = 1'b1;
            end
            default: ;
        endcase
    end

    assign sr_exit = (state_q == ST_SR_HOLD) && !standby;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             overrun <= 1'b0;
        else if (active && match && busy_cycle) overrun <= 1'b1;
    end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import dref_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    input  logic             dram_busy,
    input  logic             standby,
    output logic             ras_n,
    output logic             cas_n,
    output logic             refresh_req,
    output logic             ext_hold,
    output logic             dram_block,
    output logic             overrun,
    output logic [CNT_W-1:0] count_out
);
    logic             en_q;
    logic             hold_mode_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cmp_q;
    logic [2:0]       space_q;
    logic             ctrl_wr, cnt_wr;
    logic             tick, match, in_self, sr_exit, active;

    assign ctrl_wr = cfg_we && (cfg_addr == ADDR_CTRL);
    assign cnt_wr  = cfg_we && (cfg_addr == ADDR_CNT);
    assign active  = en_q && (space_q != 3'b000);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            hold_mode_q <= 1'b0;
            sel_q       <= '0;
            cmp_q       <= '0;
            space_q     <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                ADDR_CTRL: begin
                    en_q        <= cfg_wdata[0];
                    hold_mode_q <= cfg_wdata[1];
                    sel_q       <= cfg_wdata[4:2];
                end
                ADDR_CMP:   cmp_q   <= cfg_wdata[CNT_W-1:0];
                ADDR_SPACE: space_q <= cfg_wdata[2:0];
                default: ;
            endcase
        end
    end

    dref_prescaler #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel_q),
        .restart (ctrl_wr || sr_exit || in_self),
        .tick    (tick)
    );

    dref_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .hold   (in_self),
        .clear  (sr_exit),
        .ld_we  (cnt_wr),
        .ld_val (cfg_wdata[CNT_W-1:0]),
        .cmp    (cmp_q),
        .cnt    (count_out),
        .match  (match)
    );

    dref_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .match       (match),
        .dram_busy   (dram_busy),
        .standby     (standby),
        .hold_mode   (hold_mode_q),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .refresh_req (refresh_req),
        .ext_hold    (ext_hold),
        .dram_block  (dram_block),
        .overrun     (overrun),
        .in_self     (in_self),
        .sr_exit     (sr_exit)
    );
endmodule

// File: rtl/dref_checker.sv
module dref_checker (
    input logic clk,
    input logic rst_n,
    input logic dram_busy,
    input logic ras_n,
    input logic cas_n,
    input logic ext_hold,
    input logic dram_block,
    input logic overrun
);
    // R6 / R10: row strobe only falls after column strobe was already low
    p_cas_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    // R6: row strobe never low without column strobe
    p_ras_with_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R7: strobe activity never starts over an ongoing DRAM access
    p_wait_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(!dram_busy));

    // R8: external hold only while strobes are active
    p_hold_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hold |-> (!cas_n && dram_block));

    // R9: overrun is sticky
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R6: strobes active implies DRAM access blocked
    p_block_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> dram_block);
endmodule

bind dram_refresh_ctrl dref_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dram_busy  (dram_busy),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .ext_hold   (ext_hold),
    .dram_block (dram_block),
    .overrun    (overrun)
);

// File: tb/dram_refresh_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic       dram_busy = 1'b0;
    logic       standby = 1'b0;
    logic       ras_n, cas_n, refresh_req, ext_hold, dram_block, overrun;
    logic [7:0] count_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dram_refresh_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .dram_busy(dram_busy), .standby(standby),
        .ras_n(ras_n), .cas_n(cas_n), .refresh_req(refresh_req),
        .ext_hold(ext_hold), .dram_block(dram_block), .overrun(overrun),
        .count_out(count_out)
    );

    function automatic int ratio_of(input int sel);
        int r;
        case (sel)
            1: r = 2;    2: r = 8;    3: r = 32;   4: r = 128;
            5: r = 512;  6: r = 2048; 7: r = 4096; default: r = 0;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] ctrl_word(input bit en, input bit hold, input int sel);
        return {3'b000, 3'(sel), hold, en};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dram_busy = 1'b0; standby = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup(input int sel, input int cmp, input bit hold);
        wr(2'd3, 8'd1);
        wr(2'd1, 8'(cmp));
        wr(2'd2, 8'd0);
        wr(2'd0, ctrl_word(1'b1, hold, sel));
    endtask

    // waits at negedges until refresh_req is 1; returns cycles waited or -1
    task automatic wait_req(input int limit, output int waited);
        waited = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (refresh_req) begin waited = i; break; end
        end
    endtask

    task automatic cbr_sequence(input bit hold);
        int w;
        setup(1, 15, hold);
        wait_req(200, w);
        check(w >= 0, "R4 request", w, 0);
        check(count_out == 8'd0, "R4 counter cleared", count_out, 0);
        check(ras_n && cas_n, "R6 strobes high while pending", {ras_n, cas_n}, 3);
        @(negedge clk);
        check(!cas_n && ras_n, "R6 cas leads", {ras_n, cas_n}, 2);
        check(ext_hold == hold, "R8 hold lead", ext_hold, hold);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check(!cas_n && !ras_n, "R6 both low", {ras_n, cas_n}, 0);
            check(ext_hold == hold, "R8 hold both", ext_hold, hold);
        end
        @(negedge clk);
        check(ras_n && cas_n && dram_block, "R6 precharge", {ras_n, cas_n, dram_block}, 7);
        check(!ext_hold, "R8 hold released", ext_hold, 0);
        @(negedge clk);
        check(!dram_block && !refresh_req, "R6 back to idle", {dram_block, refresh_req}, 0);
    endtask

    initial begin
        int w, sel, cmp, exp_p, t0, t1;
        bit ok;
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ras_n && cas_n && !refresh_req && !ext_hold && !dram_block && !overrun,
              "R1 outputs", {ras_n, cas_n, refresh_req, ext_hold, dram_block, overrun}, 48);
        check(count_out == 0, "R1 counter", count_out, 0);

        // R2 select 000 holds the counter
        wr(2'd3, 8'd1);
        wr(2'd2, 8'd5);
        wr(2'd0, ctrl_word(1'b1, 1'b0, 0));
        ok = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (count_out != 8'd5 || refresh_req) ok = 1'b0;
        end
        check(ok, "R2 stopped counter", count_out, 5);

        // R5 space type 000: no refresh
        do_reset();
        wr(2'd3, 8'd0);
        wr(2'd1, 8'd1);
        wr(2'd0, ctrl_word(1'b1, 1'b0, 1));
        ok = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (refresh_req || !cas_n || !ras_n) ok = 1'b0;
        end
        check(ok, "R5 no space", refresh_req, 0);

        // R5 enable 0: no refresh
        do_reset();
        wr(2'd3, 8'd4);
        wr(2'd1, 8'd1);
        wr(2'd0, ctrl_word(1'b0, 1'b0, 1));
        ok = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (refresh_req || !cas_n) ok = 1'b0;
        end
        check(ok, "R5 disabled", refresh_req, 0);

        // R6 / R8 CBR sequence with both hold modes
        do_reset();
        cbr_sequence(1'b0);
        do_reset();
        cbr_sequence(1'b1);

        // R7 busy defers the strobes
        do_reset();
        dram_busy = 1'b1;
        setup(1, 15, 1'b0);
        wait_req(200, w);
        check(w >= 0, "R7 request raised", w, 0);
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!cas_n || !refresh_req) ok = 1'b0;
        end
        check(ok, "R7 waits for busy", cas_n, 1);
        dram_busy = 1'b0;
        @(negedge clk);
        check(!cas_n && ras_n, "R7 cas after release", {ras_n, cas_n}, 2);

        // R9 overrun by fastest interval with bus held busy
        do_reset();
        dram_busy = 1'b1;
        setup(1, 0, 1'b0);
        repeat (12) @(negedge clk);
        check(overrun, "R9 overrun set", overrun, 1);
        dram_busy = 1'b0;
        wr(2'd0, ctrl_word(1'b0, 1'b0, 0));
        repeat (10) @(negedge clk);
        check(overrun, "R9 overrun sticky", overrun, 1);

        // R10 self-refresh
        do_reset();
        setup(1, 200, 1'b0);
        repeat (7) @(negedge clk);
        standby = 1'b1;
        @(negedge clk);
        check(!cas_n && ras_n, "R10 cas first", {ras_n, cas_n}, 2);
        @(negedge clk);
        t0 = count_out;
        ok = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (cas_n || ras_n || count_out != t0) ok = 1'b0;
        end
        check(ok, "R10 held low, counter frozen", {ras_n, cas_n}, 0);
        standby = 1'b0;
        @(negedge clk);
        check(ras_n && cas_n && count_out == 0, "R10 wake", count_out, 0);
        repeat (10) @(negedge clk);
        check(count_out == 8'd5, "R10 resume from zero", count_out, 5);

        // R3 / R4 random intervals: distance between request rises
        for (int it = 0; it < 20; it++) begin
            do_reset();
            sel = 1 + ($urandom % 3);
            cmp = $urandom % 16;
            if (ratio_of(sel) * (cmp + 1) < 8) cmp = 7;
            exp_p = ratio_of(sel) * (cmp + 1);
            setup(sel, cmp, 1'($urandom % 2));
            wait_req(2000, w);
            t0 = cycles;
            repeat (2) @(negedge clk);
            wait_req(2000, w);
            t1 = cycles;
            check(w >= 0 && (t1 - t0) == exp_p, "R3 R4 interval", t1 - t0, exp_p);
            check(!overrun, "R9 no false overrun", overrun, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule